// File: doc/BRIEF.md
# Full-Frame CCD Clock Sequencer

This block produces the logic-level clock phases for a full-frame CCD sensor whose image area feeds two horizontal shift registers. A single start request runs one complete frame cycle. First the whole image area is emptied into the clearing drain by a train of image-gate pulses. Next comes an exposure interval, measured in line periods, with an antiblooming burst at the head of each period. Last, the frame is read out one line at a time. Each readout line starts with a vertical line transfer in a blanking window and is followed by a serial shift of the two horizontal registers in antiphase. Each register gets a reset pulse ahead of every pixel.

Exposure length, the serial clock count per line and the antiblooming burst length are taken from input ports at the moment a start is accepted, and are held until the frame ends. The serial count has a floor, so a line always empties both registers, dummy elements included. Level shifting to the sensor's analog clock voltages and edge shaping are done outside this block.

Top module: `ccd_frame_seq`

## Requirements
- R1: After reset every gate output, `busy_o`, `line_valid_o` and `frame_done_o` are low, and they stay low until a start is accepted.
- R2: A `start_i` seen in idle is accepted at that clock edge, and `busy_o` is high from the next cycle up to and including the frame-done cycle. A `start_i` while busy is ignored.
- R3: The clear phase issues exactly LINES image-gate pulses. Each pulse is CLR_HALF cycles high and then CLR_HALF cycles low, and the transfer gate is held high for the whole clear phase.
- R4: The exposure phase lasts the sampled exposure count times EXP_LINE_CYC cycles. A count of zero goes straight from clear to readout.
- R5: In each exposure line period the antiblooming gate is high on the even cycle offsets 0, 2, 4, ... below twice the sampled burst count. The burst is cut short at the end of the line period.
- R6: Each of the LINES readout lines opens with a blanking window: XFER_CYC cycles with image gate and transfer gate both high, then GUARD_CYC cycles with both low.
- R7: After each blanking window come N pixel periods, each four quarters of QTR_CYCLES cycles. Serial gate 1 is high in quarters 0 and 1 and serial gate 2 in quarters 2 and 3, so the two are in antiphase.
- R8: In every pixel period reset gate 2 is high exactly in quarter 1 and reset gate 1 exactly in quarter 3. Each pulse comes just before its register's gate rises.
- R9: N equals the overclock input sampled at start, raised to MIN_SERIAL when it is smaller.
- R10: `line_valid_o` is high exactly during the serial pixel periods. It is never high together with the image, transfer or antiblooming gate.
- R11: After the last pixel of the last line, `frame_done_o` is high for one cycle with `busy_o` still high. The block is idle in the following cycle.
- R12: Changes on the exposure, overclock and burst inputs after a start is accepted have no effect on the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run one frame cycle |
| exp_lines_i | input | EXP_W | Exposure length in line periods |
| overclock_i | input | OC_W | Serial clocks per readout line |
| ab_pulses_i | input | AB_W | Antiblooming pulses per burst |
| iag_o | output | 1 | Image-area gate |
| abg_o | output | 1 | Antiblooming gate |
| trg_o | output | 1 | Transfer gate |
| srg1_o | output | 1 | Serial-register gate 1 |
| srg2_o | output | 1 | Serial-register gate 2 |
| rst1_o | output | 1 | Reset gate for register 1 |
| rst2_o | output | 1 | Reset gate for register 2 |
| busy_o | output | 1 | Frame cycle in progress |
| line_valid_o | output | 1 | Serial shift period active |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench compares every output on every busy cycle against a stream built from the requirements. The hard cases are:
- A zero exposure. A design that miscounts here would still spend a line period exposing.
- An overclock below the floor. A design that skips the clamp would shorten every line.
- A burst longer than its line period. A design that does not cut the burst would spill antiblooming pulses into the next phase or wrap its counter.
- Input changes and a repeated start in the middle of a frame. A design that re-samples the settings or restarts would shift the whole stream from that point on.
It also checks the first and last cycle of each window: an off-by-one in the clear, blanking or pixel counters changes the frame length and moves every later edge.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CLEAR  = 3'd1,
        ST_EXPOSE = 3'd2,
        ST_HBLANK = 3'd3,
        ST_SHIFT  = 3'd4,
        ST_DONE   = 3'd5
    } seq_state_t;

    // quarter index inside a pixel period
    localparam logic [1:0] QTR_RST2 = 2'd1;
    localparam logic [1:0] QTR_RST1 = 2'd3;

endpackage

// File: rtl/ccdseq_hclk.sv
module ccdseq_hclk #(
    parameter int QTR_CYCLES = 5,
    parameter int OC_W       = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [OC_W-1:0] npix,
    output logic            srg1,
    output logic            srg2,
    output logic            rst1,
    output logic            rst2,
    output logic            line_end
);
    import ccdseq_pkg::*;

    localparam int QW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [QW-1:0] Q_LAST = QW'(QTR_CYCLES - 1);

    typedef struct packed {
        logic [QW-1:0]   qc;
        logic [1:0]      sub;
        logic [OC_W-1:0] pix;
    } hclk_t;

    hclk_t h_q, h_d;
    logic  q_last;
    logic  pix_last;

    assign q_last   = (h_q.qc == Q_LAST);
    assign pix_last = (h_q.pix == npix - 1'b1);

    always_comb begin
        h_d = h_q;
        if (!en) begin
            h_d = '0;
        end else if (q_last) begin
            h_d.qc  = '0;
            h_d.sub = h_q.sub + 2'd1;
            if (h_q.sub == 2'd3) begin
                h_d.pix = pix_last ? '0 : h_q.pix + 1'b1;
            end
        end else begin
            h_d.qc = h_q.qc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign srg1     = en && !h_q.sub[1];
    assign srg2     = en &&  h_q.sub[1];
    assign rst1     = en && (h_q.sub == QTR_RST1);
    assign rst2     = en && (h_q.sub == QTR_RST2);
    assign line_end = en && q_last && (h_q.sub == 2'd3) && pix_last;

    // R8: reset of register 1 only while its gate is low
    a_r8_rst1_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        rst1 |-> (!srg1 && !rst2));
    // R8: reset of register 2 only while its gate is low
    a_r8_rst2_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        rst2 |-> (!srg2 && !rst1));
    // R7: pixel counter stays inside the sampled count
    a_r7_pix_bound: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (h_q.pix < npix));

endmodule

// File: rtl/ccdseq_ctrl.sv
module ccdseq_ctrl #(
    parameter int LINES        = 1024,
    parameter int CLR_HALF     = 50,
    parameter int EXP_LINE_CYC = 1280,
    parameter int XFER_CYC     = 20,
    parameter int GUARD_CYC    = 10,
    parameter int MIN_SERIAL   = 524,
    parameter int EXP_W        = 16,
    parameter int OC_W         = 11,
    parameter int AB_W         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [EXP_W-1:0] exp_lines,
    input  logic [OC_W-1:0]  overclock,
    input  logic [AB_W-1:0]  ab_pulses,
    input  logic             line_end,
    output logic             shift_en,
    output logic [OC_W-1:0]  npix,
    output logic             busy,
    output logic             frame_done,
    output logic             iag,
    output logic             abg,
    output logic             trg
);
    import ccdseq_pkg::*;

    localparam int HB_SPAN  = XFER_CYC + GUARD_CYC;
    localparam int CLR_SPAN = 2 * CLR_HALF;
    localparam int SPAN_A   = (CLR_SPAN > HB_SPAN) ? CLR_SPAN : HB_SPAN;
    localparam int CNT_SPAN = (SPAN_A > EXP_LINE_CYC) ? SPAN_A : EXP_LINE_CYC;
    localparam int CNT_W    = (CNT_SPAN > 2) ? $clog2(CNT_SPAN) : 1;
    localparam int LINE_W   = (LINES > 2) ? $clog2(LINES) : 1;

    localparam logic [CNT_W-1:0]  CLR_LAST  = CNT_W'(CLR_SPAN - 1);
    localparam logic [CNT_W-1:0]  EXP_LAST  = CNT_W'(EXP_LINE_CYC - 1);
    localparam logic [CNT_W-1:0]  HB_LAST   = CNT_W'(HB_SPAN - 1);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);
    localparam logic [OC_W-1:0]   OC_FLOOR  = OC_W'(MIN_SERIAL);

    typedef struct packed {
        seq_state_t       st;
        logic [CNT_W-1:0] cnt;
        logic [LINE_W-1:0] line;
        logic [EXP_W-1:0] ecnt;
        logic [EXP_W-1:0] expn;
        logic [OC_W-1:0]  oc;
        logic [AB_W-1:0]  ab;
    } ctrl_t;

    ctrl_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st   = ST_CLEAR;
                    c_d.cnt  = '0;
                    c_d.line = '0;
                    c_d.expn = exp_lines;
                    c_d.oc   = (overclock < OC_FLOOR) ? OC_FLOOR : overclock;
                    c_d.ab   = ab_pulses;
                end
            end
            ST_CLEAR: begin
                if (c_q.cnt == CLR_LAST) begin
                    c_d.cnt = '0;
                    if (c_q.line == LINE_LAST) begin
                        c_d.line = '0;
                        c_d.ecnt = '0;
                        c_d.st   = (c_q.expn == '0) ? ST_HBLANK : ST_EXPOSE;
                    end else begin
                        c_d.line = c_q.line + 1'b1;
                    end
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            ST_EXPOSE: begin
                if (c_q.cnt == EXP_LAST) begin
                    c_d.cnt = '0;
                    if (c_q.ecnt == c_q.expn - 1'b1) c_d.st = ST_HBLANK;
                    else                             c_d.ecnt = c_q.ecnt + 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            ST_HBLANK: begin
                if (c_q.cnt == HB_LAST) begin
                    c_d.cnt = '0;
                    c_d.st  = ST_SHIFT;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (line_end) begin
                    if (c_q.line == LINE_LAST) begin
                        c_d.st = ST_DONE;
                    end else begin
                        c_d.line = c_q.line + 1'b1;
                        c_d.st   = ST_HBLANK;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    logic in_xfer;
    assign in_xfer    = (c_q.st == ST_HBLANK) && (32'(c_q.cnt) < XFER_CYC);
    assign iag        = ((c_q.st == ST_CLEAR) && (32'(c_q.cnt) < CLR_HALF)) || in_xfer;
    assign trg        = (c_q.st == ST_CLEAR) || in_xfer;
    assign abg        = (c_q.st == ST_EXPOSE) && !c_q.cnt[0] &&
                        (32'(c_q.cnt) < (32'(c_q.ab) << 1));
    assign shift_en   = (c_q.st == ST_SHIFT);
    assign npix       = c_q.oc;
    assign busy       = (c_q.st != ST_IDLE);
    assign frame_done = (c_q.st == ST_DONE);

    // R9: a running frame never uses fewer serial clocks than the floor
    a_r9_oc_floor: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (c_q.oc >= OC_FLOOR));
    // R4: exposure is only entered with a nonzero count
    a_r4_expose_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_EXPOSE) |-> (c_q.expn != '0));
    // R12: sampled settings hold while the frame runs
    a_r12_settings_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(c_q.oc) && $stable(c_q.expn) && $stable(c_q.ab)));
    // R5: antiblooming only during exposure, never next to line transfer
    a_r5_abg_alone: assert property (@(posedge clk) disable iff (!rst_n)
        abg |-> (!iag && !trg && !shift_en));

endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq #(
    parameter int LINES        = 1024,
    parameter int CLR_HALF     = 50,
    parameter int EXP_LINE_CYC = 1280,
    parameter int XFER_CYC     = 20,
    parameter int GUARD_CYC    = 10,
    parameter int QTR_CYCLES   = 5,
    parameter int MIN_SERIAL   = 524,
    parameter int EXP_W        = 16,
    parameter int OC_W         = 11,
    parameter int AB_W         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [EXP_W-1:0] exp_lines_i,
    input  logic [OC_W-1:0]  overclock_i,
    input  logic [AB_W-1:0]  ab_pulses_i,
    output logic             iag_o,
    output logic             abg_o,
    output logic             trg_o,
    output logic             srg1_o,
    output logic             srg2_o,
    output logic             rst1_o,
    output logic             rst2_o,
    output logic             busy_o,
    output logic             line_valid_o,
    output logic             frame_done_o
);

    logic            shift_en;
    logic            line_end;
    logic [OC_W-1:0] npix;

    ccdseq_ctrl #(
        .LINES(LINES), .CLR_HALF(CLR_HALF), .EXP_LINE_CYC(EXP_LINE_CYC),
        .XFER_CYC(XFER_CYC), .GUARD_CYC(GUARD_CYC), .MIN_SERIAL(MIN_SERIAL),
        .EXP_W(EXP_W), .OC_W(OC_W), .AB_W(AB_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start_i),
        .exp_lines(exp_lines_i), .overclock(overclock_i), .ab_pulses(ab_pulses_i),
        .line_end(line_end), .shift_en(shift_en), .npix(npix),
        .busy(busy_o), .frame_done(frame_done_o),
        .iag(iag_o), .abg(abg_o), .trg(trg_o)
    );

    ccdseq_hclk #(
        .QTR_CYCLES(QTR_CYCLES), .OC_W(OC_W)
    ) u_hclk (
        .clk(clk), .rst_n(rst_n), .en(shift_en), .npix(npix),
        .srg1(srg1_o), .srg2(srg2_o), .rst1(rst1_o), .rst2(rst2_o),
        .line_end(line_end)
    );

    assign line_valid_o = shift_en;

    // R10: no vertical transfer or antiblooming while pixels shift
    a_r10_shift_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid_o |-> (!iag_o && !trg_o && !abg_o));
    // R7: serial gates in antiphase during a shift period
    a_r7_antiphase: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid_o |-> (srg1_o != srg2_o));
    // R11: frame-done is a single cycle followed by idle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> (!frame_done_o && !busy_o));
    // R2: busy cannot drop before the frame-done cycle
    a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !frame_done_o) |=> busy_o);
    // R1: serial gates silent outside a shift period
    a_r1_serial_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !line_valid_o |-> (!srg1_o && !srg2_o && !rst1_o && !rst2_o));

endmodule

// File: tb/ccd_frame_seq_test.sv
`timescale 1ns/1ps
module ccd_frame_seq_test;

    localparam int LINES = 4, CLR_HALF = 2, EXP_LINE_CYC = 8;
    localparam int XFER_CYC = 2, GUARD_CYC = 1, QTR_CYCLES = 1, MIN_SERIAL = 3;
    localparam int EXP_W = 16, OC_W = 11, AB_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [EXP_W-1:0] exp_lines_i = '0;
    logic [OC_W-1:0]  overclock_i = '0;
    logic [AB_W-1:0]  ab_pulses_i = '0;
    logic iag_o, abg_o, trg_o, srg1_o, srg2_o, rst1_o, rst2_o;
    logic busy_o, line_valid_o, frame_done_o;

    always #2.5 clk = ~clk;

    ccd_frame_seq #(
        .LINES(LINES), .CLR_HALF(CLR_HALF), .EXP_LINE_CYC(EXP_LINE_CYC),
        .XFER_CYC(XFER_CYC), .GUARD_CYC(GUARD_CYC), .QTR_CYCLES(QTR_CYCLES),
        .MIN_SERIAL(MIN_SERIAL), .EXP_W(EXP_W), .OC_W(OC_W), .AB_W(AB_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .exp_lines_i(exp_lines_i), .overclock_i(overclock_i), .ab_pulses_i(ab_pulses_i),
        .iag_o(iag_o), .abg_o(abg_o), .trg_o(trg_o), .srg1_o(srg1_o), .srg2_o(srg2_o),
        .rst1_o(rst1_o), .rst2_o(rst2_o), .busy_o(busy_o),
        .line_valid_o(line_valid_o), .frame_done_o(frame_done_o)
    );

    int checks = 0;
    int errors = 0;
    int busy_cycles = 0;

    // bit order: busy lv done iag abg trg srg1 srg2 rst1 rst2
    logic [9:0] exp_q[$];
    string      tag_q[$];

    function automatic logic [9:0] observed();
        return {busy_o, line_valid_o, frame_done_o, iag_o, abg_o, trg_o,
                srg1_o, srg2_o, rst1_o, rst2_o};
    endfunction

    task automatic push(input logic [9:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    // builds the expected stream from the requirements
    task automatic build_frame(input int e, input int oc, input int ab, input string st);
        int n;
        n = (oc < MIN_SERIAL) ? MIN_SERIAL : oc;               // R9
        for (int l = 0; l < LINES; l++)                          // R3
            for (int c = 0; c < 2*CLR_HALF; c++)
                push({1'b1, 1'b0, 1'b0, (c < CLR_HALF), 1'b0, 1'b1, 4'b0000}, "R3");
        for (int x = 0; x < e; x++)                              // R4, R5
            for (int c = 0; c < EXP_LINE_CYC; c++)
                push({1'b1, 2'b00, 1'b0, ((c % 2 == 0) && (c < 2*ab)), 1'b0, 4'b0000}, "R5");
        for (int l = 0; l < LINES; l++) begin
            for (int c = 0; c < XFER_CYC + GUARD_CYC; c++)       // R6
                push({1'b1, 2'b00, (c < XFER_CYC), 1'b0, (c < XFER_CYC), 4'b0000}, "R6");
            for (int p = 0; p < n; p++)                          // R7, R8, R10
                for (int s = 0; s < 4; s++)
                    for (int q = 0; q < QTR_CYCLES; q++)
                        push({1'b1, 1'b1, 1'b0, 3'b000, (s < 2), (s >= 2), (s == 3), (s == 1)}, st);
        end
        push({1'b1, 1'b0, 1'b1, 7'b0}, "R11");                   // R11
    endtask

    // monitor: scoreboard compare on every busy cycle
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && busy_o) begin
                busy_cycles++;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 busy beyond expected frame end: actual %b expected idle", observed());
                end else begin
                    logic [9:0] ev;
                    string tg;
                    ev = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    if (observed() !== ev) begin
                        errors++;
                        $display("FAIL %s outputs at %0t: actual %b expected %b", tg, $time, observed(), ev);
                    end
                end
            end
        end
    end

    task automatic check_idle(input string tg);
        checks++;
        if (observed() !== 10'b0) begin
            errors++;
            $display("FAIL %s idle outputs: actual %b expected %b", tg, observed(), 10'b0);
        end
    endtask

    task automatic run_frame(input int e, input int oc, input int ab,
                             input bit disturb, input string st);
        int expected_len;
        @(negedge clk);
        exp_lines_i = EXP_W'(e);
        overclock_i = OC_W'(oc);
        ab_pulses_i = AB_W'(ab);
        start_i = 1'b1;
        busy_cycles = 0;
        build_frame(e, oc, ab, st);
        expected_len = exp_q.size();
        @(negedge clk);
        start_i = 1'b0;
        if (disturb) begin
            // R12 and R2: new settings and a repeated start mid-frame
            repeat (20) @(negedge clk);
            exp_lines_i = EXP_W'(9);
            overclock_i = OC_W'(17);
            ab_pulses_i = AB_W'(1);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (40) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check_idle("R11");
        // R4: frame length follows exposure count and line count
        checks++;
        if (busy_cycles != expected_len) begin
            errors++;
            $display("FAIL R4 frame length: actual %0d expected %0d", busy_cycles, expected_len);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R1");
        run_frame(2, 5, 2, 1'b0, "R7");   // nominal frame, R8 resets checked in stream
        run_frame(0, 1, 0, 1'b0, "R9");   // zero exposure (R4), overclock below floor
        run_frame(1, 4, 7, 1'b1, "R12");  // burst cut at line end (R5), mid-frame changes
        run_frame(3, 3, 4, 1'b0, "R10");  // burst exactly fills line, floor value itself
        repeat (3) @(negedge clk);
        check_idle("R1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule